// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block sits between static logic and a region that is rebuilt while the rest of the chip keeps running. It isolates that region on request. Software writes requests into a small 32-bit register space. The controller then raises a freeze output that gates the bridge traffic. It waits for the region to drain, can hold the region in reset while frozen, and later releases both. Completion is reported through two sticky status flags, and exactly one of them is set whenever the bridge is settled.

Requests that do not fit the current state have no effect on the outputs. Each one is recorded, by request type, in a capture register that software clears by writing one. A read-only identifier register lets software confirm the controller version before it uses the block.

Top module: `frz_bridge_ctrl`

## Requirements
- R1: After reset the status register reads 2 (unfrozen done), control and capture read 0, and freeze_o and region_rst_o are low.
- R2: The register map uses byte offsets 0 status, 4 control, 8 capture and 12 version. Version reads the VERSION_ID parameter (default 2). Every other offset reads 0. Writes to status and version change nothing.
- R3: A write to control with bit 0 set while the status is unfrozen-done raises freeze_o on the next cycle and clears the status to 0 while the region drains.
- R4: While draining, status bit 0 (frozen done, status value 1) sets after DRAIN_CYCLES consecutive cycles with region_idle high. A low region_idle cycle restarts the count.
- R5: A write with control bit 1 while frozen-done raises region_rst_o on the next cycle. A later write of 0 to control lowers it, and the status stays frozen-done.
- R6: A write with control bit 2 while frozen-done lowers freeze_o and region_rst_o on the next cycle. The status is 0 for that one cycle and reads 2 on the cycle after it.
- R7: A freeze request (bit 0) while not unfrozen-done sets capture bit 0 and leaves the state unchanged.
- R8: A reset request (bit 1) while not frozen-done sets capture bit 1 and leaves region_rst_o low.
- R9: An unfreeze request (bit 2) while not frozen-done sets capture bit 2 and leaves the state unchanged.
- R10: Capture bits are sticky. Writing a value with bit 0 set to offset 8 clears all of them. A write with bit 0 clear has no effect.
- R11: Status bits 0 and 1 are never set together.
- R12: Control reads back only the requests accepted by the last control write. A reset bit written together with an accepted unfreeze bit is dropped and is not flagged as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe, one write per cycle |
| csr_addr | input | ADDR_W | Byte address of the access |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data for csr_addr, combinational |
| region_idle | input | 1 | Region reports no traffic in flight |
| freeze_o | output | 1 | Gates bridge traffic to the region |
| region_rst_o | output | 1 | Holds the region in reset |

## Verification
The assertions assume one register access per cycle, a write strobe that is never X after reset, and a region_idle level that is free to change on any cycle. The bench drives all inputs one time unit after a rising edge, issues single-cycle writes only, and toggles region_idle during the drain so that the restart path is exercised. Capture writes and control writes never share a cycle, because the interface carries a single address.

// File: rtl/frz_bridge_ctrl.sv
module frz_bridge_ctrl #(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 32,
  parameter int DRAIN_CYCLES = 8,
  parameter logic [31:0] VERSION_ID = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              region_idle,
  output logic              freeze_o,
  output logic              region_rst_o
);
  localparam int CNT_W = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYCLES - 1);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_ILL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_VER  = ADDR_W'(12);

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_HELD, S_RELEASE} st_t;

  st_t             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]      ctrl_q;
  logic [2:0]      ill_q;
  logic [1:0]      status_w;
  logic [2:0]      req, acc, bad;
  logic            wr_ctrl, wr_ill, in_run, in_held;

  assign in_run   = (st_q == S_RUN);
  assign in_held  = (st_q == S_HELD);
  assign wr_ctrl  = csr_wr && (csr_addr == OFF_CTRL);
  assign wr_ill   = csr_wr && (csr_addr == OFF_ILL);
  assign req      = csr_wdata[2:0];
  assign acc      = req & {in_held, in_held & ~csr_wdata[2], in_run};
  assign bad      = req & {~in_held, ~in_held, ~in_run};
  assign status_w = {in_run, in_held};

  assign freeze_o     = (st_q == S_DRAIN) || in_held;
  assign region_rst_o = ctrl_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_DRAIN: begin
          if (!region_idle) begin
            cnt_q <= '0;
          end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            st_q  <= S_HELD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RELEASE: st_q <= S_RUN;
        default: ;
      endcase
      if (wr_ctrl && acc[0]) begin
        st_q  <= S_DRAIN;
        cnt_q <= '0;
      end
      if (wr_ctrl && acc[2]) st_q <= S_RELEASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ill_q  <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= acc;
      ill_q  <= ill_q | bad;
    end else if (wr_ill && csr_wdata[0]) begin
      ill_q  <= '0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      OFF_STAT: csr_rdata[1:0] = status_w;
      OFF_CTRL: csr_rdata[2:0] = ctrl_q;
      OFF_ILL:  csr_rdata[2:0] = ill_q;
      OFF_VER:  csr_rdata      = DATA_W'(VERSION_ID);
      default:  csr_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/frz_bridge_chk.sv
module frz_bridge_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DATA_W-1:0] csr_wdata,
  input logic              freeze_o,
  input logic              region_rst_o,
  input logic [1:0]        st,
  input logic [2:0]        ill
);
  logic ctl_wr, ill_wr;
  assign ctl_wr = csr_wr && (csr_addr == ADDR_W'(4));
  assign ill_wr = csr_wr && (csr_addr == ADDR_W'(8));

  assert_freeze_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && csr_wdata[0] && st == 2'b10) |=> freeze_o);

  assert_rst_inside_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    region_rst_o |-> freeze_o);

  assert_unfreeze_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && csr_wdata[2] && st == 2'b01) |=> (!freeze_o && !region_rst_o && st == 2'b00));

  assert_unfreeze_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && !freeze_o) |=> (st == 2'b10));

  assert_frozen_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b01 && !(ctl_wr && csr_wdata[2])) |=> (st == 2'b01));

  assert_bad_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && csr_wdata[1] && st != 2'b01) |=> !region_rst_o);

  assert_capture_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_wr && csr_wdata[0]) |=> (ill == 3'b000));

  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) <= 1);
endmodule

bind frz_bridge_ctrl frz_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .freeze_o(freeze_o), .region_rst_o(region_rst_o),
  .st(status_w), .ill(ill_q)
);

// File: tb/tb_frz_bridge_ctrl.sv
`timescale 1ns/1ps
module tb_frz_bridge_ctrl;
  localparam int DRAIN = 8;
  localparam logic [31:0] VER = 32'h2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic idle = 1'b0;
  logic frz, rrst;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;

  int m_st = 0, m_cnt = 0, m_ctrl = 0, m_ill = 0, m_old = 0, m_nc = 0, m_nb = 0;

  always #4 clk = ~clk;

  frz_bridge_ctrl #(.ADDR_W(5), .DATA_W(32), .DRAIN_CYCLES(DRAIN), .VERSION_ID(VER)) dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(wr), .csr_addr(addr), .csr_wdata(wdata),
    .csr_rdata(rdata), .region_idle(idle), .freeze_o(frz), .region_rst_o(rrst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_rd(input logic [4:0] a);
    case (a)
      5'd0:  return (m_st == 0) ? 32'd2 : (m_st == 2) ? 32'd1 : 32'd0;
      5'd4:  return 32'(m_ctrl);
      5'd8:  return 32'(m_ill);
      5'd12: return VER;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ctrl = 0; m_ill = 0;
    end else begin
      m_old = m_st;
      if (m_old == 1) begin
        if (!idle) m_cnt = 0;
        else if (m_cnt == DRAIN - 1) begin m_st = 2; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else if (m_old == 3) m_st = 0;
      if (wr && addr == 5'd4) begin
        m_nc = 0; m_nb = 0;
        if (wdata[0]) begin
          if (m_old == 0) begin m_nc |= 1; m_st = 1; m_cnt = 0; end else m_nb |= 1;
        end
        if (wdata[2]) begin
          if (m_old == 2) begin m_nc |= 4; m_st = 3; end else m_nb |= 4;
        end
        if (wdata[1]) begin
          if (m_old == 2) begin if (!wdata[2]) m_nc |= 2; end else m_nb |= 2;
        end
        m_ctrl = m_nc;
        m_ill |= m_nb;
      end else if (wr && addr == 5'd8 && wdata[0]) m_ill = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 model freeze_o", {31'd0, frz}, {31'd0, (m_st == 1 || m_st == 2)});
      chk("R5 model region_rst_o", {31'd0, rrst}, {31'd0, m_ctrl[1]});
      chk("R2 model rdata", rdata, m_rd(addr));
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic pins(input logic ef, input logic er, input string tag);
    @(negedge clk);
    chk(tag, {30'd0, frz, rrst}, {30'd0, ef, er});
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    cmp_en = 1'b1;

    rd_reg(5'd0, 32'd2, "R1 status after reset");
    rd_reg(5'd4, 32'd0, "R1 control after reset");
    rd_reg(5'd8, 32'd0, "R1 capture after reset");
    pins(1'b0, 1'b0, "R1 outputs after reset");

    rd_reg(5'd12, VER, "R2 version");
    rd_reg(5'd16, 32'd0, "R2 unmapped 16");
    rd_reg(5'd2, 32'd0, "R2 unmapped 2");
    wr_reg(5'd0, 32'hFFFF_FFFF);
    rd_reg(5'd0, 32'd2, "R2 status write ignored");
    wr_reg(5'd12, 32'h0);
    rd_reg(5'd12, VER, "R2 version write ignored");

    wr_reg(5'd4, 32'd2);
    rd_reg(5'd8, 32'd2, "R8 reset while unfrozen flagged");
    pins(1'b0, 1'b0, "R8 region reset stays low");
    rd_reg(5'd4, 32'd0, "R12 rejected reset not in control");
    wr_reg(5'd4, 32'd4);
    rd_reg(5'd8, 32'd6, "R9 unfreeze while unfrozen flagged");
    rd_reg(5'd0, 32'd2, "R9 state unchanged");
    wr_reg(5'd8, 32'd2);
    rd_reg(5'd8, 32'd6, "R10 write without bit0 ignored");
    wr_reg(5'd8, 32'd1);
    rd_reg(5'd8, 32'd0, "R10 write one clears");

    idle = 1'b0;
    wr_reg(5'd4, 32'd1);
    rd_reg(5'd0, 32'd0, "R3 status zero while draining");
    pins(1'b1, 1'b0, "R3 freeze raised");
    idle = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    idle = 1'b0;
    @(posedge clk); #1;
    idle = 1'b1;
    repeat (7) begin @(posedge clk); #1; end
    rd_reg(5'd0, 32'd0, "R4 not done after 7 idle cycles");
    rd_reg(5'd0, 32'd1, "R4 frozen done after 8 idle cycles");

    wr_reg(5'd4, 32'd1);
    rd_reg(5'd8, 32'd1, "R7 freeze while frozen flagged");
    rd_reg(5'd0, 32'd1, "R7 state unchanged");
    wr_reg(5'd8, 32'd1);

    wr_reg(5'd4, 32'd2);
    pins(1'b1, 1'b1, "R5 region reset raised");
    rd_reg(5'd4, 32'd2, "R12 accepted reset in control");
    wr_reg(5'd4, 32'd0);
    pins(1'b1, 1'b0, "R5 region reset lowered");
    rd_reg(5'd0, 32'd1, "R5 still frozen");

    wr_reg(5'd4, 32'd2);
    wr_reg(5'd4, 32'd0);
    wr_reg(5'd4, 32'd4);
    rd_reg(5'd0, 32'd0, "R6 status zero in release cycle");
    rd_reg(5'd0, 32'd2, "R6 unfrozen done next cycle");
    pins(1'b0, 1'b0, "R6 outputs released");
    wr_reg(5'd4, 32'd0);

    wr_reg(5'd4, 32'd3);
    rd_reg(5'd8, 32'd2, "R8 reset beside freeze flagged");
    rd_reg(5'd4, 32'd1, "R12 only freeze accepted");
    repeat (DRAIN) begin @(posedge clk); #1; end
    rd_reg(5'd0, 32'd1, "R4 frozen with steady idle");
    wr_reg(5'd8, 32'd1);
    wr_reg(5'd4, 32'd6);
    rd_reg(5'd4, 32'd4, "R12 reset dropped beside unfreeze");
    rd_reg(5'd8, 32'd0, "R12 dropped reset not flagged");
    rd_reg(5'd0, 32'd2, "R11 status back to unfrozen");
    pins(1'b0, 1'b0, "R6 region reset low after unfreeze");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule